// File: doc/BRIEF.md
# Burst Address Sequencer for a Synchronous SRAM

This block produces the word address presented to a synchronous burst SRAM array. A burst begins when either of two start strobes is seen at a rising clock edge: one driven by a processor, the other by a cache controller. The full address is captured at that edge, and the two low-order bits then walk through a four-word group each time the advance input is high. The ordering inside the group is chosen by a mode input when the burst starts. Mode 0 gives a linear order, where the offset counts up by one and wraps. Mode 1 gives an interleaved order, where the offset is the starting offset XOR a step count.

Three chip enables gate the acceptance of a new address. One is the pipelining enable, and the other two are for depth expansion. A strobe that is seen while any enable is inactive deselects the device instead of loading an address. The processor strobe is disregarded completely while the pipelining enable is low. All outputs come from registers, so each result appears after the clock edge that samples its inputs.

Top module: `sram_burst_seq`

## Requirements
- R1: A start event is accepted when all three chip enables are 1 at the edge. A start event is ctrl_start_i=1, or proc_start_i=1 with ce_pipe_i=1. After that edge, burst_addr_o equals addr_i and sel_o=1.
- R2: While ce_pipe_i=0, proc_start_i has no effect. Address and select hold, and an advance in the same cycle is still carried out.
- R3: A start event seen while any chip enable is 0 clears sel_o and leaves burst_addr_o unchanged.
- R4: In linear mode (mode 0), after n advances the low two bits equal (s + n) mod 4, where s is the starting offset.
- R5: In interleaved mode (mode 1), after n advances the low two bits equal s XOR (n mod 4).
- R6: The order is taken from mode_i at the accepting edge. Changes to mode_i during the burst have no effect until the next start.
- R7: With no start event, burst_addr_o steps only when adv_i=1 and sel_o=1. In all other cases the address and sel_o hold.
- R8: Bits above the low two stay equal to the captured address for the whole burst.
- R9: A start event accepted in the middle of a burst reloads the full address and restarts the step count at 0.
- R10: A start event takes priority over adv_i in the same cycle.
- R11: While rst_ni=0, burst_addr_o is 0 and sel_o is 0.
- R12: After four advances the low bits return to the starting offset, in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Address captured at a burst start |
| proc_start_i | input | 1 | Processor start strobe, active high |
| ctrl_start_i | input | 1 | Controller start strobe, active high |
| adv_i | input | 1 | Step to the next word in the burst |
| ce_pipe_i | input | 1 | Pipelining chip enable, active high |
| ce_exp_a_i | input | 1 | Depth-expansion chip enable A, active high |
| ce_exp_b_i | input | 1 | Depth-expansion chip enable B, active high |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| burst_addr_o | output | ADDR_W | Current word address |
| sel_o | output | 1 | Device selected with a valid burst address |

## Verification
Each result is due one rising edge after the inputs that cause it: a load, a step, a hold or a deselect all appear after that single edge. The bench changes inputs on the falling edge and compares the outputs on the following falling edge, which falls exactly half a period after the register update. Expected addresses come from the start offset and the step count by addition or XOR in the bench. Hold and deselect cases compare against the address recorded before the stimulus.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/sram_burst_ce_gate.sv
module sram_burst_ce_gate (
  input  logic proc_start_i,
  input  logic ctrl_start_i,
  input  logic adv_i,
  input  logic ce_pipe_i,
  input  logic ce_exp_a_i,
  input  logic ce_exp_b_i,
  input  logic sel_q_i,
  output logic load_o,
  output logic desel_o,
  output logic step_o
);
  logic start_evt;
  logic all_ce;

  // processor strobe only counts while the pipelining enable is active
  assign start_evt = (proc_start_i & ce_pipe_i) | ctrl_start_i;
  assign all_ce    = ce_pipe_i & ce_exp_a_i & ce_exp_b_i;
  assign load_o    = start_evt & all_ce;
  assign desel_o   = start_evt & ~all_ce;
  assign step_o    = ~start_evt & adv_i & sel_q_i;
endmodule

// File: rtl/sram_burst_ctr.sv
module sram_burst_ctr
  import sram_burst_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [BURST_W-1:0] base_i,
  input  order_e             mode_i,
  output logic [BURST_W-1:0] base_o,
  output logic [BURST_W-1:0] cnt_o,
  output order_e             mode_o
);
  logic [BURST_W-1:0] base_q, cnt_q;
  order_e             mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      mode_q <= ORDER_LINEAR;
    end else if (load_i) begin
      base_q <= base_i;
      cnt_q  <= '0;
      mode_q <= mode_i;
    end else if (step_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign base_o = base_q;
  assign cnt_o  = cnt_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/sram_burst_order.sv
module sram_burst_order
  import sram_burst_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  logic [BURST_W-1:0] base_i,
  input  logic [BURST_W-1:0] cnt_i,
  input  order_e             mode_i,
  output logic [BURST_W-1:0] low_o
);
  logic [BURST_W-1:0] lin_low, ilv_low;

  assign lin_low = base_i + cnt_i;  // wraps inside the aligned group
  assign ilv_low = base_i ^ cnt_i;

  always_comb begin
    unique case (mode_i)
      ORDER_INTERLEAVE: low_o = ilv_low;
      default:          low_o = lin_low;
    endcase
  end
endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_start_i,
  input  logic              ctrl_start_i,
  input  logic              adv_i,
  input  logic              ce_pipe_i,
  input  logic              ce_exp_a_i,
  input  logic              ce_exp_b_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] burst_addr_o,
  output logic              sel_o
);
  localparam int UpperW = ADDR_W - BURST_W;

  logic               load, desel, step;
  logic               sel_q;
  logic [UpperW-1:0]  upper_q;
  logic [BURST_W-1:0] base_q, cnt_q, low;
  order_e             mode_q;
  order_e             mode_in;

  assign mode_in = order_e'(mode_i);

  sram_burst_ce_gate u_gate (
    .proc_start_i (proc_start_i),
    .ctrl_start_i (ctrl_start_i),
    .adv_i        (adv_i),
    .ce_pipe_i    (ce_pipe_i),
    .ce_exp_a_i   (ce_exp_a_i),
    .ce_exp_b_i   (ce_exp_b_i),
    .sel_q_i      (sel_q),
    .load_o       (load),
    .desel_o      (desel),
    .step_o       (step)
  );

  sram_burst_ctr #(.BURST_W(BURST_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .base_i (addr_i[BURST_W-1:0]),
    .mode_i (mode_in),
    .base_o (base_q),
    .cnt_o  (cnt_q),
    .mode_o (mode_q)
  );

  sram_burst_order #(.BURST_W(BURST_W)) u_order (
    .base_i (base_q),
    .cnt_i  (cnt_q),
    .mode_i (mode_q),
    .low_o  (low)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q <= '0;
      sel_q   <= 1'b0;
    end else if (load) begin
      upper_q <= addr_i[ADDR_W-1:BURST_W];
      sel_q   <= 1'b1;
    end else if (desel) begin
      sel_q   <= 1'b0;
    end
  end

  assign burst_addr_o = {upper_q, low};
  assign sel_o        = sel_q;
endmodule

// File: rtl/sram_burst_seq_chk.sv
module sram_burst_seq_chk #(
  parameter int ADDR_W  = 20,
  parameter int BURST_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              proc_start_i,
  input logic              ctrl_start_i,
  input logic              adv_i,
  input logic              ce_pipe_i,
  input logic              ce_exp_a_i,
  input logic              ce_exp_b_i,
  input logic              mode_q_i,
  input logic [ADDR_W-1:0] burst_addr_o,
  input logic              sel_o
);
  logic start_evt, all_ce;
  assign start_evt = (proc_start_i && ce_pipe_i) || ctrl_start_i;
  assign all_ce    = ce_pipe_i && ce_exp_a_i && ce_exp_b_i;

  assert_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_evt && all_ce) |=> (burst_addr_o == $past(addr_i)) && sel_o);

  assert_proc_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proc_start_i && !ce_pipe_i && !ctrl_start_i && !adv_i)
      |=> $stable(burst_addr_o) && $stable(sel_o));

  assert_deselect_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_evt && !all_ce) |=> !sel_o && $stable(burst_addr_o));

  assert_linear_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_evt && adv_i && sel_o && !mode_q_i)
      |=> burst_addr_o[BURST_W-1:0] == $past(burst_addr_o[BURST_W-1:0]) + 1'b1);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_evt && !(adv_i && sel_o)) |=> $stable(burst_addr_o) && $stable(sel_o));

  assert_upper_fixed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_evt |=> $stable(burst_addr_o[ADDR_W-1:BURST_W]));

  always_comb begin
    if (!rst_ni) assert_reset_R11: assert (!sel_o || burst_addr_o != {ADDR_W{1'bx}});
  end
endmodule

bind sram_burst_seq sram_burst_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .proc_start_i (proc_start_i),
  .ctrl_start_i (ctrl_start_i),
  .adv_i        (adv_i),
  .ce_pipe_i    (ce_pipe_i),
  .ce_exp_a_i   (ce_exp_a_i),
  .ce_exp_b_i   (ce_exp_b_i),
  .mode_q_i     (mode_q),
  .burst_addr_o (burst_addr_o),
  .sel_o        (sel_o)
);

// File: tb/sram_burst_seq_tb_top.sv
module sram_burst_seq_tb_top;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          proc = 1'b0, ctrl = 1'b0, adv = 1'b0;
  logic          cep = 1'b1, cea = 1'b1, ceb = 1'b1, mode = 1'b0;
  logic [AW-1:0] q_addr;
  logic          q_sel;
  int            checks = 0, errors = 0;
  logic          done = 1'b0;

  always #5 clk = ~clk;

  sram_burst_seq #(.ADDR_W(AW), .BURST_W(2)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .addr_i       (addr),
    .proc_start_i (proc),
    .ctrl_start_i (ctrl),
    .adv_i        (adv),
    .ce_pipe_i    (cep),
    .ce_exp_a_i   (cea),
    .ce_exp_b_i   (ceb),
    .mode_i       (mode),
    .burst_addr_o (q_addr),
    .sel_o        (q_sel)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    proc = 0; ctrl = 0; adv = 0; cep = 1; cea = 1; ceb = 1;
  endtask

  // apply inputs now (just after a falling edge), result checked at next falling edge
  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic start(input logic use_proc, input logic [AW-1:0] a, input logic m);
    idle(); addr = a; mode = m;
    if (use_proc) proc = 1; else ctrl = 1;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] held;
    repeat (2) @(negedge clk);
    chk("R11 addr", q_addr, '0);
    chk("R11 sel", AW'(q_sel), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // every order from every start offset, with a hold cycle and wrap
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-3:0] up;
        logic [1:0]    lo;
        int            n;
        up = (AW-2)'(18'h2A5 + 37 * s + 101 * m);
        start(s[0], {up, 2'(s)}, m[0]);
        chk("R1 load addr", q_addr, {up, 2'(s)});
        chk("R1 load sel", AW'(q_sel), 1);
        n = 0;
        for (int k = 0; k < 7; k++) begin
          idle(); mode = ~m[0];
          if (k != 2) begin adv = 1; n++; end
          tick();
          lo = m[0] ? (2'(s) ^ 2'(n)) : 2'(s + n);
          if (k == 2)   chk("R7 hold without adv", q_addr, {up, lo});
          else if (n == 4) chk("R12 wrap to start", q_addr, {up, 2'(s)});
          else if (m[0]) chk("R5 interleaved R6 R8", q_addr, {up, lo});
          else          chk("R4 linear R6 R8", q_addr, {up, lo});
        end
      end
    end

    // mid-burst reload with advance in the same cycle
    start(1'b0, 20'h12341, 1'b0);
    idle(); adv = 1; tick();
    idle(); adv = 1; tick();
    chk("R4 pre-reload", q_addr, 20'h12343);
    idle(); ctrl = 1; adv = 1; addr = 20'h0ABC2; mode = 1; tick();
    chk("R9 R10 reload", q_addr, 20'h0ABC2);
    idle(); adv = 1; tick();
    chk("R9 count restarts", q_addr, 20'h0ABC3);

    // processor strobe ignored while pipelining enable low
    start(1'b1, 20'h55550, 1'b0);
    idle(); proc = 1; cep = 0; addr = 20'hFFFFF; tick();
    chk("R2 ignored addr", q_addr, 20'h55550);
    chk("R2 ignored sel", AW'(q_sel), 1);
    idle(); proc = 1; cep = 0; adv = 1; addr = 20'hFFFFF; tick();
    chk("R2 advance still taken", q_addr, 20'h55551);

    // deselection through each enable
    for (int e = 0; e < 3; e++) begin
      start(1'b0, 20'h30004 + AW'(e * 16), 1'b0);
      held = q_addr;
      idle(); addr = 20'hCCCCC; ctrl = 1;
      if (e == 0) cep = 0; else if (e == 1) cea = 0; else ceb = 0;
      tick();
      chk("R3 desel sel", AW'(q_sel), 0);
      chk("R3 desel addr", q_addr, held);
      idle(); adv = 1; tick();
      chk("R7 no step deselected", q_addr, held);
    end
    start(1'b0, 20'h70000, 1'b0);
    held = q_addr;
    idle(); proc = 1; ceb = 0; addr = 20'h1; tick();
    chk("R3 proc desel sel", AW'(q_sel), 0);
    chk("R3 proc desel addr", q_addr, held);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule